// File: doc/BRIEF.md
# Programmable DRAM Address Bit Mapper

This block converts between a DRAM coordinate tuple and a linear physical address. The tuple has 18 row bits, 10 column bits, 2 bank bits, 2 bank-group bits, 2 rank bits, 3 logical-rank bits and 1 channel bit, 38 bits in all. Each of these bits has its own 6-bit position field, which names the address bit it occupies. The position fields sit five to a 32-bit configuration word, in eight words. Most system software and error-reporting logic use this to turn a logged error coordinate into an address, and to turn a target address into coordinates for a match or inject unit.

Both directions run at the same time, from the same configuration. The scatter path places each coordinate bit at its programmed address bit and ORs the bits together. The gather path picks each coordinate bit out of an input address at its programmed position. A clash flag goes high when two coordinate bits are programmed to the same address bit. All results are registered once, under a clock enable. A position at or above the address width counts as unmapped: it contributes nothing forward and reads as zero in reverse. With the default 64-bit address every 6-bit position is in range.

Top module: `dram_addr_mapper`

## Requirements
- R1: One cycle after a clock edge with `map_en` high, `out_addr` holds, for each coordinate bit set at the inputs, a one at the address bit its position field names. Coordinate index k runs row 0..17 (k=0..17), column 0..9 (18..27), bank 0..1 (28..29), group 0..1 (30..31), rank 0..1 (32..33), logical rank 0..2 (34..36), channel (37).
- R2: Address bits that no set coordinate bit maps to are zero in `out_addr`. All-zero coordinates give an all-zero address.
- R3: One cycle after an enabled edge, each coordinate output bit equals the bit of `addr_in` at that coordinate's programmed position.
- R4: The 18-bit row is `in_row_hi` shifted left by 10, ORed with `in_row_lo`. Row bit 10+n is `in_row_hi[n]`. The reverse row output is split in the same way.
- R5: The field for coordinate index k is at bits 6f+5:6f of word w. Word w is bits 32w+31:32w of `cfg_words`. The pairs (w,f) are: rows 0..14 in words 0..2, fields 0..4, five rows per word in order. Rows 15..17 are word 3, fields 0..2. Column 0 is word 3, field 4. Columns 1..5 are word 4, fields 0..4. Columns 6..9 are word 5, fields 0..3. Bank 0 is word 5, field 4. Bank 1, group 0 and group 1 are word 6, fields 0, 1 and 2. Channel is word 6, field 3. Rank 0..1 and logical rank 0..2 are word 7, fields 0..4.
- R6: These configuration bits have no effect on any output: bits 31:30 of every word, word 3 field 3, and word 6 field 4.
- R7: `out_clash` is high one cycle after an enabled edge exactly when two coordinate indices share the same position value.
- R8: When several set coordinate bits share a position, that address bit is their OR, a single one.
- R9: While `map_en` is low, every output holds its value, whatever the data and configuration inputs do.
- R10: While reset is held, and after it, all outputs are zero until the first enabled edge. Reset is asserted asynchronously and released through a two-stage synchroniser.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| map_en | input | 1 | Clock enable for all result registers |
| cfg_words | input | 256 | Eight packed 32-bit position words |
| in_row_lo | input | 10 | Row bits 9:0 for the scatter path |
| in_row_hi | input | 8 | Row bits 17:10 for the scatter path |
| in_col | input | 10 | Column for the scatter path |
| in_bank | input | 2 | Bank for the scatter path |
| in_grp | input | 2 | Bank group for the scatter path |
| in_rank | input | 2 | Rank for the scatter path |
| in_lrank | input | 3 | Logical rank for the scatter path |
| in_chan | input | 1 | Channel for the scatter path |
| addr_in | input | 64 | Address for the gather path |
| out_addr | output | 64 | Scattered address |
| out_row_lo | output | 10 | Gathered row bits 9:0 |
| out_row_hi | output | 8 | Gathered row bits 17:10 |
| out_col | output | 10 | Gathered column |
| out_bank | output | 2 | Gathered bank |
| out_grp | output | 2 | Gathered bank group |
| out_rank | output | 2 | Gathered rank |
| out_lrank | output | 3 | Gathered logical rank |
| out_chan | output | 1 | Gathered channel |
| out_clash | output | 1 | Two coordinate bits share a position |

## Verification
A field unpacked from the wrong word or bit offset moves one coordinate bit to a wrong address bit. This shows in `out_addr` and in the matching gathered output one cycle after the first enabled edge at which that coordinate bit is set. Random coordinates under a scattered, collision-free map expose this within a few vectors. A faulty clash comparison shows as a wrong `out_clash` on the first enabled edge after the configuration changes. A broken enable or reset path changes the outputs on the very next edge.

// File: rtl/dam_pkg.sv
package dam_pkg;

  localparam int POS_W    = 6;
  localparam int WORD_W   = 32;
  localparam int N_WORD   = 8;
  localparam int CFG_W    = N_WORD * WORD_W;

  localparam int N_ROW_LO = 10;
  localparam int N_ROW_HI = 8;
  localparam int N_ROW    = N_ROW_LO + N_ROW_HI;
  localparam int N_COL    = 10;
  localparam int N_BANK   = 2;
  localparam int N_GRP    = 2;
  localparam int N_RANK   = 2;
  localparam int N_LRANK  = 3;
  localparam int N_CHAN   = 1;

  // Coordinate vector layout, LSB first
  localparam int ROW_B    = 0;
  localparam int COL_B    = ROW_B + N_ROW;
  localparam int BANK_B   = COL_B + N_COL;
  localparam int GRP_B    = BANK_B + N_BANK;
  localparam int RANK_B   = GRP_B + N_GRP;
  localparam int LRANK_B  = RANK_B + N_RANK;
  localparam int CHAN_B   = LRANK_B + N_LRANK;
  localparam int N_COORD  = CHAN_B + N_CHAN;

  typedef logic [POS_W-1:0]   pos_t;
  typedef logic [N_COORD-1:0] coord_t;

  // LSB of the position field of coordinate index i inside the packed words
  function automatic int src_lsb(input int i);
    int w;
    int f;
    if (i < ROW_B + 15) begin
      w = i / 5;
      f = i % 5;
    end else if (i < COL_B) begin
      w = 3;
      f = i - (ROW_B + 15);
    end else if (i == COL_B) begin
      w = 3;
      f = 4;
    end else if (i < COL_B + 6) begin
      w = 4;
      f = i - (COL_B + 1);
    end else if (i < BANK_B) begin
      w = 5;
      f = i - (COL_B + 6);
    end else if (i == BANK_B) begin
      w = 5;
      f = 4;
    end else if (i < GRP_B) begin
      w = 6;
      f = 0;
    end else if (i < RANK_B) begin
      w = 6;
      f = i - GRP_B + 1;
    end else if (i < CHAN_B) begin
      w = 7;
      f = i - RANK_B;
    end else begin
      w = 6;
      f = 3;
    end
    return w * WORD_W + f * POS_W;
  endfunction

endpackage

// File: rtl/dam_pos_unpack.sv
module dam_pos_unpack
  import dam_pkg::*;
(
  input  logic [CFG_W-1:0]         cfg_words,
  output pos_t [N_COORD-1:0]       pos_vec
);

  for (genvar i = 0; i < N_COORD; i++) begin : g_fld
    localparam int LSB = src_lsb(i);
    assign pos_vec[i] = cfg_words[LSB +: POS_W];
  end

  // Reserved bits are deliberately left without a consumer
  logic unused_cfg;
  assign unused_cfg = ^cfg_words;

endmodule

// File: rtl/dam_scatter.sv
module dam_scatter
  import dam_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  coord_t                   crd,
  input  pos_t [N_COORD-1:0]       pos_vec,
  output logic [ADDR_W-1:0]        addr
);

  for (genvar j = 0; j < ADDR_W; j++) begin : g_abit
    logic [N_COORD-1:0] hit;
    for (genvar i = 0; i < N_COORD; i++) begin : g_src
      assign hit[i] = crd[i] & (pos_vec[i] == POS_W'(j));
    end
    assign addr[j] = |hit;
  end

endmodule

// File: rtl/dam_gather.sv
module dam_gather
  import dam_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic [ADDR_W-1:0]        addr,
  input  pos_t [N_COORD-1:0]       pos_vec,
  output coord_t                   crd
);

  localparam int SPAN = 1 << POS_W;

  // Positions beyond the address width read as zero
  logic [SPAN-1:0] addr_ext;

  always_comb begin
    addr_ext = '0;
    addr_ext[ADDR_W-1:0] = addr;
  end

  for (genvar i = 0; i < N_COORD; i++) begin : g_pick
    assign crd[i] = addr_ext[pos_vec[i]];
  end

endmodule

// File: rtl/dam_clash.sv
module dam_clash
  import dam_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  pos_t [N_COORD-1:0]       pos_vec,
  output logic                     clash
);

  logic [N_COORD-1:0] mapped;

  for (genvar i = 0; i < N_COORD; i++) begin : g_map
    assign mapped[i] = int'(pos_vec[i]) < ADDR_W;
  end

  always_comb begin
    clash = 1'b0;
    for (int i = 0; i < N_COORD; i++) begin
      for (int k = i + 1; k < N_COORD; k++) begin
        if (mapped[i] && (pos_vec[i] == pos_vec[k])) clash = 1'b1;
      end
    end
  end

endmodule

// File: rtl/dram_addr_mapper.sv
module dram_addr_mapper
  import dam_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  map_en,
  input  logic [CFG_W-1:0]      cfg_words,
  input  logic [N_ROW_LO-1:0]   in_row_lo,
  input  logic [N_ROW_HI-1:0]   in_row_hi,
  input  logic [N_COL-1:0]      in_col,
  input  logic [N_BANK-1:0]     in_bank,
  input  logic [N_GRP-1:0]      in_grp,
  input  logic [N_RANK-1:0]     in_rank,
  input  logic [N_LRANK-1:0]    in_lrank,
  input  logic [N_CHAN-1:0]     in_chan,
  input  logic [ADDR_W-1:0]     addr_in,
  output logic [ADDR_W-1:0]     out_addr,
  output logic [N_ROW_LO-1:0]   out_row_lo,
  output logic [N_ROW_HI-1:0]   out_row_hi,
  output logic [N_COL-1:0]      out_col,
  output logic [N_BANK-1:0]     out_bank,
  output logic [N_GRP-1:0]      out_grp,
  output logic [N_RANK-1:0]     out_rank,
  output logic [N_LRANK-1:0]    out_lrank,
  output logic [N_CHAN-1:0]     out_chan,
  output logic                  out_clash
);

  // Reset: asserted at once, released after two clock edges
  logic rs_meta;
  logic run_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta   <= 1'b0;
      run_rst_n <= 1'b0;
    end else begin
      rs_meta   <= 1'b1;
      run_rst_n <= rs_meta;
    end
  end

  // Coordinate tuple: row is {hi, lo}, so hi lands at row bit 10 upward
  coord_t crd_vec;
  assign crd_vec = {in_chan, in_lrank, in_rank, in_grp, in_bank, in_col,
                    in_row_hi, in_row_lo};

  pos_t [N_COORD-1:0] pos_vec;
  logic [ADDR_W-1:0]  fwd_addr;
  coord_t             rev_crd;
  logic               clash_c;

  dam_pos_unpack u_unpack (
    .cfg_words (cfg_words),
    .pos_vec   (pos_vec)
  );

  dam_scatter #(.ADDR_W(ADDR_W)) u_scatter (
    .crd     (crd_vec),
    .pos_vec (pos_vec),
    .addr    (fwd_addr)
  );

  dam_gather #(.ADDR_W(ADDR_W)) u_gather (
    .addr    (addr_in),
    .pos_vec (pos_vec),
    .crd     (rev_crd)
  );

  dam_clash #(.ADDR_W(ADDR_W)) u_clash (
    .pos_vec (pos_vec),
    .clash   (clash_c)
  );

  // Next state
  logic [ADDR_W-1:0] addr_q, addr_d;
  coord_t            rev_q, rev_d;
  logic              clash_q, clash_d;

  always_comb begin
    addr_d  = addr_q;
    rev_d   = rev_q;
    clash_d = clash_q;
    if (map_en) begin
      addr_d  = fwd_addr;
      rev_d   = rev_crd;
      clash_d = clash_c;
    end
  end

  // State registers
  always_ff @(posedge clk or negedge run_rst_n) begin
    if (!run_rst_n) begin
      addr_q  <= '0;
      rev_q   <= '0;
      clash_q <= 1'b0;
    end else begin
      addr_q  <= addr_d;
      rev_q   <= rev_d;
      clash_q <= clash_d;
    end
  end

  assign out_addr   = addr_q;
  assign out_row_lo = rev_q[ROW_B +: N_ROW_LO];
  assign out_row_hi = rev_q[ROW_B + N_ROW_LO +: N_ROW_HI];
  assign out_col    = rev_q[COL_B +: N_COL];
  assign out_bank   = rev_q[BANK_B +: N_BANK];
  assign out_grp    = rev_q[GRP_B +: N_GRP];
  assign out_rank   = rev_q[RANK_B +: N_RANK];
  assign out_lrank  = rev_q[LRANK_B +: N_LRANK];
  assign out_chan   = rev_q[CHAN_B +: N_CHAN];
  assign out_clash  = clash_q;

endmodule

// File: rtl/dam_checker.sv
module dam_checker
  import dam_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input logic              clk,
  input logic              run_rst_n,
  input logic              map_en,
  input coord_t            crd_vec,
  input logic [ADDR_W-1:0] addr_in,
  input logic [ADDR_W-1:0] addr_out,
  input coord_t            rev_vec,
  input logic              clash_out
);

  // R9
  hold_out_chk: assert property (@(posedge clk) disable iff (!run_rst_n)
    !map_en |=> ($stable(addr_out) && $stable(rev_vec) && $stable(clash_out)));

  // R1
  fwd_count_chk: assert property (@(posedge clk) disable iff (!run_rst_n)
    map_en |=> (clash_out || ($countones(addr_out) == $past($countones(crd_vec)))));

  // R8
  fwd_or_chk: assert property (@(posedge clk) disable iff (!run_rst_n)
    map_en |=> ($countones(addr_out) <= $past($countones(crd_vec))));

  // R3
  rev_zero_chk: assert property (@(posedge clk) disable iff (!run_rst_n)
    (map_en && (addr_in == '0)) |=> (rev_vec == '0));

  // R3
  rev_ones_chk: assert property (@(posedge clk) disable iff (!run_rst_n)
    (map_en && (&addr_in)) |=> (&rev_vec));

  // R2
  fwd_zero_chk: assert property (@(posedge clk) disable iff (!run_rst_n)
    (map_en && (crd_vec == '0)) |=> (addr_out == '0));

endmodule

bind dram_addr_mapper dam_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .run_rst_n (run_rst_n),
  .map_en    (map_en),
  .crd_vec   (crd_vec),
  .addr_in   (addr_in),
  .addr_out  (out_addr),
  .rev_vec   (rev_q),
  .clash_out (out_clash)
);

// File: tb/test_dram_addr_mapper.sv
`timescale 1ns/1ps
module test_dram_addr_mapper;
  import dam_pkg::*;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic              rst_n;
  logic              map_en;
  logic [CFG_W-1:0]  cfg;
  logic [9:0]        in_row_lo;
  logic [7:0]        in_row_hi;
  logic [9:0]        in_col;
  logic [1:0]        in_bank, in_grp, in_rank;
  logic [2:0]        in_lrank;
  logic [0:0]        in_chan;
  logic [63:0]       addr_in;
  logic [63:0]       out_addr;
  logic [9:0]        out_row_lo;
  logic [7:0]        out_row_hi;
  logic [9:0]        out_col;
  logic [1:0]        out_bank, out_grp, out_rank;
  logic [2:0]        out_lrank;
  logic [0:0]        out_chan;
  logic              out_clash;

  dram_addr_mapper i_dram_addr_mapper (
    .clk(clk), .rst_n(rst_n), .map_en(map_en), .cfg_words(cfg),
    .in_row_lo(in_row_lo), .in_row_hi(in_row_hi), .in_col(in_col),
    .in_bank(in_bank), .in_grp(in_grp), .in_rank(in_rank),
    .in_lrank(in_lrank), .in_chan(in_chan), .addr_in(addr_in),
    .out_addr(out_addr), .out_row_lo(out_row_lo), .out_row_hi(out_row_hi),
    .out_col(out_col), .out_bank(out_bank), .out_grp(out_grp),
    .out_rank(out_rank), .out_lrank(out_lrank), .out_chan(out_chan),
    .out_clash(out_clash)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  logic [5:0] bp [N_COORD];

  logic [63:0] ea_q [$];
  coord_t      ec_q [$];
  logic        ek_q [$];
  string       et_q [$];

  logic [63:0] last_a;
  coord_t      last_c;
  logic        last_k;

  function automatic coord_t out_vec();
    return {out_chan, out_lrank, out_rank, out_grp, out_bank, out_col,
            out_row_hi, out_row_lo};
  endfunction

  function automatic logic [63:0] ref_scatter(coord_t c);
    logic [63:0] a = '0;
    for (int i = 0; i < N_COORD; i++) if (c[i]) a[bp[i]] = 1'b1;
    return a;
  endfunction

  function automatic coord_t ref_gather(logic [63:0] a);
    coord_t c;
    for (int i = 0; i < N_COORD; i++) c[i] = a[bp[i]];
    return c;
  endfunction

  function automatic logic ref_clash();
    logic k = 1'b0;
    for (int i = 0; i < N_COORD; i++)
      for (int j = 0; j < i; j++)
        if (bp[i] == bp[j]) k = 1'b1;
    return k;
  endfunction

  task automatic check(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic put(int w, int f, logic [5:0] v);
    cfg[w*32 + f*6 +: 6] = v;
  endtask

  // Pack the per-bit positions into the eight words (R5 layout)
  task automatic build_cfg(bit junk);
    cfg = '0;
    for (int k = 0; k < 5; k++) begin
      put(0, k, bp[k]);
      put(1, k, bp[5 + k]);
      put(2, k, bp[10 + k]);
      put(4, k, bp[19 + k]);
      put(7, k, bp[32 + k]);
    end
    for (int k = 0; k < 3; k++) put(3, k, bp[15 + k]);
    put(3, 4, bp[18]);
    for (int k = 0; k < 4; k++) put(5, k, bp[24 + k]);
    put(5, 4, bp[28]);
    put(6, 0, bp[29]);
    put(6, 1, bp[30]);
    put(6, 2, bp[31]);
    put(6, 3, bp[37]);
    if (junk) begin
      for (int w = 0; w < N_WORD; w++) cfg[w*32 + 30 +: 2] = 2'b11;
      put(3, 3, 6'h2A);
      put(6, 4, 6'h15);
    end
  endtask

  task automatic set_cfg(bit junk);
    @(negedge clk);
    map_en = 1'b0;
    build_cfg(junk);
  endtask

  task automatic drive(bit en, coord_t c, logic [63:0] a, string tag);
    @(negedge clk);
    map_en = en;
    {in_chan, in_lrank, in_rank, in_grp, in_bank, in_col, in_row_hi, in_row_lo} = c;
    addr_in = a;
    if (en) begin
      last_a = ref_scatter(c);
      last_c = ref_gather(a);
      last_k = ref_clash();
    end
    ea_q.push_back(last_a);
    ec_q.push_back(last_c);
    ek_q.push_back(last_k);
    et_q.push_back(tag);
  endtask

  function automatic coord_t rnd_c();
    return coord_t'({$urandom(), $urandom()});
  endfunction

  function automatic logic [63:0] rnd_a();
    return {$urandom(), $urandom()};
  endfunction

  // Monitor: compares one expected item per edge
  always @(posedge clk) begin
    if (ea_q.size() > 0) begin
      logic [63:0] ea;
      coord_t      ec;
      logic        ek;
      string       et;
      #1;
      ea = ea_q.pop_front();
      ec = ec_q.pop_front();
      ek = ek_q.pop_front();
      et = et_q.pop_front();
      check(out_addr == ea, et, "addr", out_addr, ea);
      check(out_vec() == ec, et, "coords", 64'(out_vec()), 64'(ec));
      check(out_clash == ek, et, "clash", 64'(out_clash), 64'(ek));
    end
  end

  task automatic check_zero(string tag);
    check(out_addr == '0, tag, "addr", out_addr, 64'd0);
    check(out_vec() == '0, tag, "coords", 64'(out_vec()), 64'd0);
    check(out_clash == 1'b0, tag, "clash", 64'(out_clash), 64'd0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    map_en = 1'b0;
    cfg = '0;
    {in_chan, in_lrank, in_rank, in_grp, in_bank, in_col, in_row_hi, in_row_lo} = '0;
    addr_in = '0;
    last_a = '0;
    last_c = '0;
    last_k = 1'b0;
    for (int i = 0; i < N_COORD; i++) bp[i] = 6'(i);
    build_cfg(1'b0);
    repeat (3) @(posedge clk);
    #1;
    check_zero("R10");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_zero("R10");

    // Identity map
    for (int n = 0; n < 8; n++) drive(1'b1, rnd_c(), rnd_a(), "R1");
    drive(1'b1, rnd_c(), 64'hFFFF_FFFF_FFFF_FFFF, "R3");

    // Scattered, collision-free map
    for (int i = 0; i < N_COORD; i++) bp[i] = 6'((i * 5 + 7) % 64);
    set_cfg(1'b0);
    for (int n = 0; n < 10; n++) drive(1'b1, rnd_c(), rnd_a(), "R5");
    drive(1'b1, coord_t'(1) << 17, 64'd0, "R4");
    drive(1'b1, coord_t'(1) << 10, 64'd1 << bp[12], "R4");
    drive(1'b1, coord_t'(1) << 9,  64'd1 << bp[9], "R4");
    drive(1'b1, '1, '0, "R2");
    drive(1'b1, '0, 64'hFFFF_FFFF_FFFF_FFFF, "R2");
    for (int n = 0; n < 4; n++) drive(1'b1, rnd_c(), rnd_a(), "R3");

    // Hold while disabled
    drive(1'b1, rnd_c(), rnd_a(), "R9");
    for (int n = 0; n < 3; n++) drive(1'b0, rnd_c(), rnd_a(), "R9");

    // Reserved configuration bits set
    set_cfg(1'b1);
    for (int n = 0; n < 8; n++) drive(1'b1, rnd_c(), rnd_a(), "R6");

    // Collisions
    bp[37] = bp[0];
    bp[36] = bp[5];
    set_cfg(1'b0);
    for (int n = 0; n < 6; n++) drive(1'b1, rnd_c(), rnd_a(), "R7");
    drive(1'b1, (coord_t'(1) << 37) | coord_t'(1), 64'd0, "R8");
    drive(1'b1, (coord_t'(1) << 36) | (coord_t'(1) << 5), 64'd1 << bp[5], "R8");

    // Back to a clean map: clash must clear
    for (int i = 0; i < N_COORD; i++) bp[i] = 6'(63 - i);
    set_cfg(1'b0);
    for (int n = 0; n < 4; n++) drive(1'b1, rnd_c(), rnd_a(), "R7");

    // Reset during operation
    wait (ea_q.size() == 0);
    @(negedge clk);
    map_en = 1'b0;
    rst_n = 1'b0;
    #1;
    check_zero("R10");
    @(negedge clk);
    rst_n = 1'b1;
    last_a = '0;
    last_c = '0;
    last_k = 1'b0;
    repeat (4) @(negedge clk);
    check_zero("R10");
    drive(1'b1, rnd_c(), rnd_a(), "R1");

    wait (ea_q.size() == 0);
    @(negedge clk);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule